// File: doc/BRIEF.md
# DMA page translation lookup

This block maps a device-side DMA I/O offset to a physical page address through a table of translation entries held in on-chip storage. The I/O offset is divided into a page number and an in-page offset according to a page shift set at run time. The page number selects one table entry. The block returns four values:

- the page-aligned I/O address,
- the translated page base,
- the in-page offset mask,
- the two-bit access code stored in the entry.

It also raises a fault flag when the requested access conflicts with that code. An index at or beyond the configured entry count gives a no-access answer and does not raise a bus error.

Lookups are a valid/ready stream with one register stage. A request is accepted when `req_valid` and `req_ready` are both high, and its answer appears with `rsp_valid` on the next cycle. When the consumer holds `rsp_ready` low, the answer stays on the outputs unchanged. `req_ready` then drops, so back-pressure reaches the requester in the same cycle.

Software fills the table one entry per cycle through a plain write port. It sets the page shift and the entry count through a plain configuration strobe. Reset empties the whole table.

Top module: `xlt_lookup`

## Requirements
- R1: A request accepted at a clock edge (req_valid and req_ready high) yields rsp_valid at that same edge's next output update, that is, one cycle of latency. req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is high and rsp_ready is low, every response output holds its value.
- R2: The entry index is req_addr shifted right by the page shift. The lookup is in range when that full-width index is below the configured entry count. The count is loaded through cfg_we and clamped to DEPTH when a larger value is written.
- R3: For an in-range lookup, with page mask PM = ~(2^shift − 1): rsp_iova = req_addr & PM and rsp_mask = ~PM.
- R4: For an in-range lookup, rsp_paddr = entry & PM.
- R5: rsp_perm holds entry bits [1:0]. Code 0 means no access, 1 read only, 2 write only and 3 read and write.
- R6: For an out-of-range lookup: rsp_perm = 0, rsp_paddr = 0, rsp_iova = 0, rsp_mask is all ones and rsp_fault = 0.
- R7: req_acc bit 0 requests a read and bit 1 requests a write. rsp_fault is 1 when a write is requested on code 1, or a read is requested on code 2. Otherwise it is 0.
- R8: After reset every entry reads as zero, so every lookup returns code 0 and address 0. The page shift resets to 12 and the entry count resets to DEPTH.
- R9: tbl_we writes tbl_data into entry tbl_idx at the clock edge. A lookup accepted at the same edge as a write to its entry returns the value the entry held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load page shift and entry count |
| cfg_shift | input | $clog2(ADDR_W) | New page shift |
| cfg_count | input | $clog2(DEPTH)+1 | New entry count |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(DEPTH) | Entry to write |
| tbl_data | input | ADDR_W | Entry value (low two bits are the access code) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | ADDR_W | I/O offset to translate |
| req_acc | input | 2 | Requested access, bit 0 read, bit 1 write |
| rsp_valid | output | 1 | Answer valid |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_iova | output | ADDR_W | Page-aligned I/O address |
| rsp_paddr | output | ADDR_W | Translated page base |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access code |
| rsp_fault | output | 1 | Requested access conflicts with code |

## Verification
The hardest case to reach is a lookup accepted at the same edge as a write to its own entry. It must see the old contents, and only a later lookup may see the new ones. The bench drives the write strobe and the request together in one cycle, then repeats the lookup. A stalled answer is the other tricky case. The bench holds rsp_ready low while a second request waits with valid high. It confirms that the first answer stays frozen and that the second answer comes out only after release. Sweeps over three page shifts and two entry counts, one of them above the table depth, cover the range boundary in every configuration.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2,
    ACC_RDWR = 2'd3
  } acc_code_e;

  localparam int unsigned DEF_PAGE_SHIFT = 12;
endpackage

// File: rtl/xlt_mask_gen.sv
module xlt_mask_gen #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SHIFT_W = $clog2(ADDR_W)
) (
  input  logic [SHIFT_W-1:0] shift,
  output logic [ADDR_W-1:0]  page_mask
);
  // complement of (page size - 1)
  always_comb page_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
endmodule

// File: rtl/xlt_cfg_regs.sv
module xlt_cfg_regs #(
  parameter int unsigned SHIFT_W = 6,
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned DEPTH   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SHIFT_W-1:0] shift_in,
  input  logic [CNT_W-1:0]   count_in,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [CNT_W-1:0]   count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= SHIFT_W'(xlt_pkg::DEF_PAGE_SHIFT);
      count_q <= CNT_MAX;
    end else if (we) begin
      shift_q <= shift_in;
      count_q <= (count_in > CNT_MAX) ? CNT_MAX : count_in;
    end
  end
endmodule

// File: rtl/xlt_entry_ram.sv
module xlt_entry_ram #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  filled;

  // storage itself is not reset; per-entry flags make cleared entries read zero
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) filled[wr_idx] <= 1'b1;
      if (rd_en) rd_data <= filled[rd_idx] ? mem[rd_idx] : '0;
    end
  end
endmodule

// File: rtl/xlt_lookup.sv
module xlt_lookup #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned SHIFT_W = $clog2(ADDR_W),
  parameter int unsigned IDX_W   = $clog2(DEPTH),
  parameter int unsigned CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [ADDR_W-1:0]  tbl_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_fault
);
  import xlt_pkg::*;

  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   count_q;
  logic [ADDR_W-1:0]  pmask;
  logic [ADDR_W-1:0]  idx_full;
  logic               in_range;
  logic               fire;
  logic [ADDR_W-1:0]  entry;

  logic               s_valid;
  logic               s_in;
  logic [ADDR_W-1:0]  s_iova;
  logic [ADDR_W-1:0]  s_pmask;
  logic [1:0]         s_acc;

  xlt_cfg_regs #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .shift_in(cfg_shift),
    .count_in(cfg_count), .shift_q(shift_q), .count_q(count_q)
  );

  xlt_mask_gen #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_mask (
    .shift(shift_q), .page_mask(pmask)
  );

  always_comb begin
    req_ready = !s_valid || rsp_ready;
    fire      = req_valid && req_ready;
    idx_full  = req_addr >> shift_q;
    in_range  = idx_full < {{(ADDR_W-CNT_W){1'b0}}, count_q};
  end

  xlt_entry_ram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
    .wr_data(tbl_data), .rd_en(fire), .rd_idx(idx_full[IDX_W-1:0]),
    .rd_data(entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_in    <= 1'b0;
      s_iova  <= '0;
      s_pmask <= '0;
      s_acc   <= '0;
    end else if (fire) begin
      s_valid <= 1'b1;
      s_in    <= in_range;
      s_iova  <= req_addr & pmask;
      s_pmask <= pmask;
      s_acc   <= req_acc;
    end else if (rsp_ready) begin
      s_valid <= 1'b0;
    end
  end

  acc_code_e code;
  always_comb begin
    code      = s_in ? acc_code_e'(entry[1:0]) : ACC_NONE;
    rsp_valid = s_valid;
    rsp_perm  = code;
    rsp_iova  = s_in ? s_iova : '0;
    rsp_paddr = s_in ? (entry & s_pmask) : '0;
    rsp_mask  = s_in ? ~s_pmask : '1;
    rsp_fault = (s_acc[1] && code == ACC_RD) || (s_acc[0] && code == ACC_WR);
  end
endmodule

// File: rtl/xlt_lookup_chk.sv
module xlt_lookup_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_iova,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] rsp_mask,
  input logic [1:0]        rsp_perm,
  input logic              rsp_fault
);
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R1
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_iova)
      && $stable(rsp_perm) && $stable(rsp_mask)); // R1
  AST_IOVA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_iova & rsp_mask) == '0); // R3
  AST_PADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_paddr & rsp_mask) == '0); // R4
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_perm == 2'd1 || rsp_perm == 2'd2)); // R7
endmodule

bind xlt_lookup xlt_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova),
  .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
  .rsp_fault(rsp_fault)
);

// File: tb/sim_xlt_lookup.sv
module sim_xlt_lookup;
  localparam int AW = 32;
  localparam int DP = 16;
  localparam int SW = $clog2(AW);
  localparam int IW = $clog2(DP);
  localparam int CW = IW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0;
  logic [SW-1:0] cfg_shift = '0;
  logic [CW-1:0] cfg_count = '0;
  logic tbl_we = 0;
  logic [IW-1:0] tbl_idx = '0;
  logic [AW-1:0] tbl_data = '0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_acc = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [AW-1:0] rsp_iova, rsp_paddr, rsp_mask;
  logic [1:0] rsp_perm;
  logic rsp_fault;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] mdl [DP];

  always #2 clk = ~clk;

  xlt_lookup #(.ADDR_W(AW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_shift(cfg_shift),
    .cfg_count(cfg_count), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int sh, input int cnt);
    @(negedge clk);
    cfg_we = 1; cfg_shift = SW'(sh); cfg_count = CW'(cnt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic put(input int i, input logic [AW-1:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IW'(i); tbl_data = v;
    @(negedge clk);
    tbl_we = 0;
    mdl[i] = v;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_acc = acc;
    @(negedge clk);
    req_valid = 0;
  endtask

  // compare current outputs against a model answer
  task automatic expect_rsp(input int idx, input int sh, input int cnt_eff,
                            input logic [AW-1:0] a, input logic [1:0] acc,
                            input logic [AW-1:0] ent);
    logic [AW-1:0] pm;
    logic [1:0] pc;
    bit flt;
    pm = ~((AW'(1) << sh) - AW'(1));
    check(rsp_valid === 1'b1, "R1 rsp_valid", 64'(rsp_valid), 64'd1);
    if (idx < cnt_eff) begin
      pc = ent[1:0];
      flt = (acc[1] && pc == 2'd1) || (acc[0] && pc == 2'd2);
      check(rsp_iova === (a & pm), "R3 iova", 64'(rsp_iova), 64'(a & pm));
      check(rsp_mask === ~pm, "R3 mask", 64'(rsp_mask), 64'(~pm));
      check(rsp_paddr === (ent & pm), "R4 paddr", 64'(rsp_paddr), 64'(ent & pm));
      check(rsp_perm === pc, "R5 perm", 64'(rsp_perm), 64'(pc));
      check(rsp_fault === flt, "R7 fault", 64'(rsp_fault), 64'(flt));
    end else begin
      check(rsp_perm === 2'd0 && rsp_paddr === '0 && rsp_iova === '0
            && rsp_mask === '1 && rsp_fault === 1'b0, "R2 R6 out of range",
            {rsp_paddr, rsp_mask}, {32'd0, 32'hFFFF_FFFF});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int shifts [3] = '{12, 8, 4};
    int counts [2] = '{10, 31};
    logic [AW-1:0] a;
    logic [AW-1:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: empty table, shift 12, count DEPTH
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R8 idle after reset",
          64'(rsp_valid), 64'd0);
    for (int i = 0; i < DP; i++) begin
      a = (AW'(i) << 12) | AW'(32'h5A3);
      lookup(a, 2'b11);
      expect_rsp(i, 12, DP, a, 2'b11, '0); // R8
    end
    // fill table
    for (int i = 0; i < DP; i++)
      put(i, 32'h5A00_0000 + AW'(i) * 32'h0013_1F07); // R9
    // sweep shifts, counts (R2 clamp via 31), indices, access kinds
    foreach (shifts[s]) foreach (counts[c]) begin
      set_cfg(shifts[s], counts[c]);
      for (int i = 0; i < DP + 4; i++) begin
        for (int k = 0; k < 4; k++) begin
          a = (AW'(i) << shifts[s]) |
              (AW'(32'h0ABC_DE37) & ((AW'(1) << shifts[s]) - AW'(1)));
          lookup(a, 2'(k));
          expect_rsp(i, shifts[s], (counts[c] > DP) ? DP : counts[c], a, 2'(k),
                     (i < DP) ? mdl[i] : '0);
        end
      end
    end
    // R9: write and lookup of the same entry in one cycle sees the old value
    set_cfg(12, DP);
    old = mdl[5];
    @(negedge clk);
    tbl_we = 1; tbl_idx = IW'(5); tbl_data = 32'hC0DE_0003;
    req_valid = 1; req_addr = 32'h0000_5123; req_acc = 2'b01;
    @(negedge clk);
    tbl_we = 0; req_valid = 0;
    mdl[5] = 32'hC0DE_0003;
    expect_rsp(5, 12, DP, 32'h0000_5123, 2'b01, old); // R9 old value
    lookup(32'h0000_5123, 2'b01);
    expect_rsp(5, 12, DP, 32'h0000_5123, 2'b01, mdl[5]); // R9 new value
    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'h0000_2000; req_acc = 2'b00;
    @(negedge clk);
    req_addr = 32'h0000_3000;
    check(rsp_valid === 1'b1 && req_ready === 1'b0, "R1 stall ready low",
          64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    check(rsp_paddr === (mdl[2] & 32'hFFFF_F000), "R1 held answer",
          64'(rsp_paddr), 64'(mdl[2] & 32'hFFFF_F000));
    check(req_ready === 1'b0, "R1 still stalled", 64'(req_ready), 64'd0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_rsp(3, 12, DP, 32'h0000_3000, 2'b00, mdl[3]); // R1 second answer
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 drains", 64'(rsp_valid), 64'd0);
    // R8 reset mid-run clears table and config
    set_cfg(4, 3);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    for (int i = 0; i < DP; i++) begin
      a = (AW'(i) << 12) | AW'(32'h00F);
      lookup(a, 2'b10);
      expect_rsp(i, 12, DP, a, 2'b10, '0); // R8
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule